// File: doc/BRIEF.md
# Split-Decode Bus Register Slave

This block is one addressable register hanging on a shared, byte-wide instrument bus. A bus master first puts an address on the bus and then raises a data strobe. The strobe either deposits a byte into the selected register or asks that register to place its contents on the data lines. The eighth address line is always the transfer direction: high asks for a read, low carries a write. The register's contents also leave the block as a parallel control word for the assembly it serves.

To keep decoding cheap, a register checks only part of the address. On the right half of the bus it compares the low nibble and ignores bits 4 to 6. On the left half it compares bits 4 to 6 and ignores the low nibble. A parameter picks the half and the slot value. A write snapshot is refreshed on every clock while the strobe is high and committed when the strobe falls. So data that changes as the strobe drops does not corrupt the register. The bus pull-ups are modelled as a resolved data level: it reads all ones whenever this register is not driving.

Top module: `bus_reg_slave`

## Requirements
- R1: While reset is asserted, and after its release until the first write, `ctrl_q` equals `RESET_VAL` (default 0x00), `drv_oe` is 0 and `bus_level` is 0xFF.
- R2: A write takes effect only once the strobe has fallen. `ctrl_q` keeps its old value while `bus_strobe` is high. It shows the new byte after the first rising clock edge at which `bus_strobe` is sampled low.
- R3: With `SIDE = SIDE_RIGHT`, the register is selected when `bus_addr[3:0]` equals the slot value. Bits 4 to 6 have no effect on selection.
- R4: With `SIDE = SIDE_LEFT`, the register is selected when `bus_addr[6:4]` equals the slot value. Bits 0 to 3 have no effect on selection.
- R5: A strobe at an address that does not select the register leaves `ctrl_q` unchanged.
- R6: A strobe with `bus_addr[7] = 1` (read direction) never changes `ctrl_q`, whatever is on `bus_wdata`.
- R7: `drv_oe` is 1 exactly when the register is selected, `bus_addr[7] = 1` and `bus_strobe = 1`. While it is 1, `bus_level` equals `ctrl_q`.
- R8: Whenever `drv_oe` is 0, `bus_level` is 0xFF, so a read of an unselected address returns all ones.
- R9: A write-direction strobe (`bus_addr[7] = 0`) never raises `drv_oe`.
- R10: The committed byte is the one on `bus_wdata` at the last clock edge on which `bus_strobe` was high. A change of `bus_wdata` in the same cycle as the strobe falls is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Bus address; the top bit is the direction (1 read, 0 write) |
| bus_strobe | input | 1 | Data strobe, active high, synchronous to `clk` |
| bus_wdata | input | DATA_W | Data lines as driven by the master on writes |
| drv_oe | output | 1 | Output enable for this register's data drivers |
| drv_data | output | DATA_W | Byte driven onto the data lines (zero when not enabled) |
| bus_level | output | DATA_W | Resolved data-line level including the pull-ups |
| ctrl_q | output | DATA_W | Register contents, fed to the controlled assembly |

## Verification
The bench holds a right-side and a left-side instance on one shared bus. It probes addresses that differ only in the ignored bits, which a full decoder would wrongly reject. It also probes addresses that differ only in the compared bits, which a decoder looking at the wrong field would wrongly accept. It checks `ctrl_q` in the middle of a strobe: a design that commits on the leading edge would already show the new byte there. It changes the data in the cycle the strobe falls: a design that samples data at the trailing edge would commit the wrong byte. Read-direction strobes carrying data check that reads never write. Reads of unselected slots check that a register which drives without being selected, or fails to release, leaves something other than 0xFF on the lines.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic {
    SIDE_RIGHT = 1'b0,
    SIDE_LEFT  = 1'b1
  } bus_side_e;

  // Width of the nibble compared by a right-side register.
  localparam int unsigned RIGHT_KEY_W = 4;
  // First address bit of the field compared by a left-side register.
  localparam int unsigned LEFT_KEY_LSB = 4;

endpackage

// File: rtl/bsr_reset_sync.sv
module bsr_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bsr_decode.sv
module bsr_decode
  import bsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter bus_side_e   SIDE   = SIDE_RIGHT,
  parameter int unsigned SLOT   = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              slot_hit,
  output logic              dir_read
);

  localparam int unsigned DIR_BIT = ADDR_W - 1;
  localparam int unsigned LEFT_W  = DIR_BIT - LEFT_KEY_LSB;

  assign dir_read = addr[DIR_BIT];

  generate
    if (SIDE == SIDE_RIGHT) begin : g_right
      localparam logic [RIGHT_KEY_W-1:0] KEY = RIGHT_KEY_W'(SLOT);
      logic unused_upper;
      assign unused_upper = ^addr[DIR_BIT-1:RIGHT_KEY_W];
      assign slot_hit = (addr[RIGHT_KEY_W-1:0] == KEY);
    end else begin : g_left
      localparam logic [LEFT_W-1:0] KEY = LEFT_W'(SLOT);
      logic unused_lower;
      assign unused_lower = ^addr[LEFT_KEY_LSB-1:0];
      assign slot_hit = (addr[DIR_BIT-1:LEFT_KEY_LSB] == KEY);
    end
  endgenerate

endmodule

// File: rtl/bsr_strobe_capture.sv
module bsr_strobe_capture #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              strobe_fell,
  output logic [ADDR_W-1:0] snap_addr,
  output logic [DATA_W-1:0] snap_data
);

  logic              strobe_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  // Snapshot refreshed on every clock while the strobe is active.
  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (strobe) begin
      addr_d = addr;
      data_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      strobe_q <= strobe;
      addr_q   <= addr_d;
      data_q   <= data_d;
    end
  end

  assign strobe_fell = strobe_q & ~strobe;
  assign snap_addr   = addr_q;
  assign snap_data   = data_q;

endmodule

// File: rtl/bsr_store.sv
module bsr_store #(
  parameter int unsigned     DATA_W    = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_en,
  input  logic [DATA_W-1:0] commit_data,
  output logic [DATA_W-1:0] value_q
);

  logic [DATA_W-1:0] value_d;

  always_comb begin
    value_d = value_q;
    if (commit_en) begin
      value_d = commit_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= RESET_VAL;
    end else begin
      value_q <= value_d;
    end
  end

endmodule

// File: rtl/bus_reg_slave.sv
module bus_reg_slave
  import bsr_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 8,
  parameter bus_side_e         SIDE      = SIDE_RIGHT,
  parameter int unsigned       SLOT      = 0,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_strobe,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              drv_oe,
  output logic [DATA_W-1:0] drv_data,
  output logic [DATA_W-1:0] bus_level,
  output logic [DATA_W-1:0] ctrl_q
);

  localparam logic [DATA_W-1:0] PULL_LEVEL = '1;

  logic              rst_int_n;
  logic              live_hit, live_rd;
  logic              snap_hit, snap_rd;
  logic              strobe_fell;
  logic [ADDR_W-1:0] snap_addr;
  logic [DATA_W-1:0] snap_data;
  logic              commit_en;

  bsr_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // Live decode for the read path, snapshot decode for the write commit.
  bsr_decode #(.ADDR_W(ADDR_W), .SIDE(SIDE), .SLOT(SLOT)) u_dec_live (
    .addr     (bus_addr),
    .slot_hit (live_hit),
    .dir_read (live_rd)
  );

  bsr_decode #(.ADDR_W(ADDR_W), .SIDE(SIDE), .SLOT(SLOT)) u_dec_snap (
    .addr     (snap_addr),
    .slot_hit (snap_hit),
    .dir_read (snap_rd)
  );

  bsr_strobe_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .strobe      (bus_strobe),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .strobe_fell (strobe_fell),
    .snap_addr   (snap_addr),
    .snap_data   (snap_data)
  );

  assign commit_en = strobe_fell & snap_hit & ~snap_rd;

  bsr_store #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) u_store (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .commit_en   (commit_en),
    .commit_data (snap_data),
    .value_q     (ctrl_q)
  );

  assign drv_oe    = live_hit & live_rd & bus_strobe;
  assign drv_data  = drv_oe ? ctrl_q : '0;
  assign bus_level = drv_oe ? drv_data : PULL_LEVEL;

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_strobe,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              drv_oe,
  input logic [DATA_W-1:0] drv_data,
  input logic [DATA_W-1:0] bus_level,
  input logic [DATA_W-1:0] ctrl_q
);

  AST_OE_ONLY_ON_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    drv_oe |-> (bus_strobe && bus_addr[ADDR_W-1])); // R7

  AST_WRITE_NEVER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !bus_addr[ADDR_W-1]) |-> !drv_oe); // R9

  AST_DRIVE_SHOWS_CONTENTS: assert property (@(posedge clk) disable iff (!rst_n)
    drv_oe |-> (bus_level == ctrl_q && drv_data == ctrl_q)); // R7

  AST_IDLE_PULLED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_oe |-> (bus_level == '1)); // R8

  AST_CHANGE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> ($past(bus_strobe, 2) && !$past(bus_strobe))); // R2

  AST_READ_DIR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> !$past(bus_addr[ADDR_W-1], 2)); // R6

  AST_COMMITS_LAST_STROBE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> (ctrl_q == $past(bus_wdata, 2))); // R10

endmodule

bind bus_reg_slave bsr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bsr_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_strobe (bus_strobe),
  .bus_wdata  (bus_wdata),
  .drv_oe     (drv_oe),
  .drv_data   (drv_data),
  .bus_level  (bus_level),
  .ctrl_q     (ctrl_q)
);

// File: tb/bus_reg_slave_bench.sv
module bus_reg_slave_bench;
  import bsr_pkg::*;

  localparam int unsigned RIGHT_SLOT = 5;
  localparam int unsigned LEFT_SLOT  = 2;
  localparam int          NVEC       = 10;

  // {addr, wdata, expected ctrl_q after, expected bus_level during strobe}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h05, 8'hA5, 8'hA5, 8'hFF},  // R2 write selected
    {8'h85, 8'h00, 8'hA5, 8'hA5},  // R7 read selected
    {8'h75, 8'h3C, 8'h3C, 8'hFF},  // R3 bits 4-6 ignored on write
    {8'h06, 8'hFF, 8'h3C, 8'hFF},  // R5 miss
    {8'h86, 8'h00, 8'h3C, 8'hFF},  // R8 read miss gives ones
    {8'hF5, 8'h00, 8'h3C, 8'h3C},  // R3 bits 4-6 ignored on read
    {8'h85, 8'h77, 8'h3C, 8'h3C},  // R6 read direction carries data
    {8'h45, 8'h00, 8'h00, 8'hFF},  // R2 write zeros
    {8'hC5, 8'h00, 8'h00, 8'h00},  // R7 read of zero
    {8'h15, 8'h81, 8'h81, 8'hFF}   // R9 write, no drive
  };

  logic       clk;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_strobe;
  logic [7:0] bus_wdata;
  logic       oe_r, oe_l;
  logic [7:0] drv_r, drv_l, lvl_r, lvl_l, ctrl_r, ctrl_l;

  int  n_checks;
  int  n_fail;
  bit  done;

  logic [7:0] pre_r, mid_r, s_lvl_r, s_lvl_l;
  logic       s_oe_r, s_oe_l;

  bus_reg_slave #(.SIDE(SIDE_RIGHT), .SLOT(RIGHT_SLOT)) u_bus_reg_slave (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
    .bus_wdata(bus_wdata), .drv_oe(oe_r), .drv_data(drv_r),
    .bus_level(lvl_r), .ctrl_q(ctrl_r)
  );

  bus_reg_slave #(.SIDE(SIDE_LEFT), .SLOT(LEFT_SLOT)) u_bus_reg_slave_left (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
    .bus_wdata(bus_wdata), .drv_oe(oe_l), .drv_data(drv_l),
    .bus_level(lvl_l), .ctrl_q(ctrl_l)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // One strobe: two clocks high, then dropped (optionally with new data).
  task automatic strobe_op(input logic [7:0] a, input logic [7:0] d,
                           input bit chg, input logic [7:0] d2);
    @(negedge clk);
    bus_addr   = a;
    bus_wdata  = d;
    bus_strobe = 1'b1;
    pre_r      = ctrl_r;
    @(negedge clk);
    s_lvl_r = lvl_r;
    s_lvl_l = lvl_l;
    s_oe_r  = oe_r;
    s_oe_l  = oe_l;
    @(negedge clk);
    mid_r = ctrl_r;
    bus_strobe = 1'b0;
    if (chg) bus_wdata = d2;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks   = 0;
    n_fail     = 0;
    done       = 1'b0;
    rst_n      = 1'b0;
    bus_addr   = 8'h00;
    bus_wdata  = 8'h00;
    bus_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ctrl in reset", ctrl_r, 8'h00);
    check("R1 level in reset", lvl_r, 8'hFF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ctrl after release", ctrl_r, 8'h00);
    check("R1 oe after release", {7'd0, oe_r}, 8'h00);
    check("R1 left level after release", lvl_l, 8'hFF);

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] a, d, er, ev, eoe;
      {a, d, er, ev} = VEC[i];
      eoe = {7'd0, (a[7] && a[3:0] == 4'(RIGHT_SLOT))};
      strobe_op(a, d, 1'b0, 8'h00);
      check("R2 held during strobe", mid_r, pre_r);
      check("R7 oe during strobe", {7'd0, s_oe_r}, eoe);
      check("R8 level during strobe", s_lvl_r, ev);
      check("R5 ctrl after strobe", ctrl_r, er);
      check("R4 left untouched by table", ctrl_l, 8'h00);
    end

    // Trailing-edge data change is not captured
    strobe_op(8'h05, 8'h5E, 1'b1, 8'h00);
    check("R10 committed byte", ctrl_r, 8'h5E);
    strobe_op(8'h65, 8'h2B, 1'b1, 8'hD4);
    check("R10 committed byte on aliased address", ctrl_r, 8'h2B);

    // Left-side decode
    strobe_op(8'h2F, 8'h5A, 1'b0, 8'h00);
    check("R4 left write low nibble ignored", ctrl_l, 8'h5A);
    check("R5 right miss on left write", ctrl_r, 8'h2B);
    strobe_op(8'hA9, 8'h00, 1'b0, 8'h00);
    check("R4 left read level", s_lvl_l, 8'h5A);
    check("R4 left oe", {7'd0, s_oe_l}, 8'h01);
    check("R8 right idle on left read", s_lvl_r, 8'hFF);
    strobe_op(8'h12, 8'h33, 1'b0, 8'h00);
    check("R5 left miss", ctrl_l, 8'h5A);
    strobe_op(8'hA5, 8'hEE, 1'b0, 8'h00);
    check("R6 left read dir no write", ctrl_l, 8'h5A);
    check("R6 right read dir no write", ctrl_r, 8'h2B);
    check("R9 right not driving on write", {7'd0, oe_r}, 8'h00);

    // Reset during operation
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 right cleared by reset", ctrl_r, 8'h00);
    check("R1 left cleared by reset", ctrl_l, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 level after second reset", lvl_r, 8'hFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule